// File: doc/BRIEF.md
# Register Write Batch Packer

This block turns a stream of register write requests into a packed instruction buffer for a separate write executor. Each request carries a 20-bit register offset, a 32-bit value and a flag that selects an indexed (auto-increment) write. Plain requests become two-word direct-write instructions. Indexed requests that repeat the offset of the most recent indexed instruction are merged into it: the value is appended and the count word at the head of that instruction is patched in place. Every instruction starts on an even word (8-byte alignment), and an odd word left after an indexed instruction is filled with zero.

When a request cannot fit in the local word RAM, it skips the buffer and appears on a register-write bypass port one cycle later. A commit input closes the batch. The buffer is zero-filled up to the next 64-byte line boundary, and the rounded tail is reported in bytes. The write pointer and the merge state are then cleared for the next batch. The executor reads the buffer through a synchronous read port.

Top module: `regwr_packer`

## Requirements
- R1: After reset, req_ready is high while commit_valid is low, bypass_valid and done_valid are low, and a commit issued before any request reports a tail of 0 bytes.
- R2: A direct request (req_indexed=0) stores two words: the value first, then {8'h01, 4'hF, offset[19:0]}. The opcode is in bits 31:24, the byte enables in bits 23:20 and the offset in bits 19:0.
- R3: An indexed request that does not merge opens a new instruction of three words: a count word of 1, then {8'h09, 4'h0, offset[19:0]}, then the value.
- R4: An indexed request whose offset equals that of the most recent instruction, when that instruction is indexed, merges into it. The value is stored at the write pointer and the count word at that instruction's start is incremented.
- R5: When an indexed request leaves the write pointer odd, the word at the write pointer is set to zero.
- R6: Merging needs a live indexed instruction. The first request after reset or commit always opens a new instruction, even when its offset is 0. So does any indexed request that follows a direct request, and any indexed request with a different offset.
- R7: Every new instruction, direct or indexed, starts at the write pointer rounded up to an even word.
- R8: A request bypasses the buffer when its words do not fit below DEPTH_WORDS. A merge needs 1 word at the pointer, a direct write 2 words and a new indexed instruction 3 words, both from the even-rounded pointer. On a bypass, bypass_valid pulses one cycle after acceptance with the request's offset and value, and the buffer is unchanged.
- R9: On commit, the word count is rounded up to a multiple of 16 words (64 bytes) and every word from the write pointer up to that boundary is zeroed. done_valid then pulses for one cycle, with done_tail_bytes set to the rounded count times 4.
- R10: After a commit, the next instruction starts at word 0 and no earlier indexed instruction can be merged into.
- R11: req_ready is low while commit_valid is high and while a multi-word write or padding is in progress. A request is accepted only on a cycle with req_valid and req_ready both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_offset | input | 20 | Register offset |
| req_value | input | 32 | Value to write |
| req_indexed | input | 1 | 1 selects an indexed write, 0 a direct write |
| commit_valid | input | 1 | Close the batch; taken when the packer is idle |
| done_valid | output | 1 | One-cycle pulse: the commit is finished |
| done_tail_bytes | output | PW+2 | Line-rounded buffer length in bytes |
| bypass_valid | output | 1 | One-cycle pulse: a write sent around the buffer |
| bypass_offset | output | 20 | Offset of the bypassed write |
| bypass_value | output | 32 | Value of the bypassed write |
| buf_rd_addr | input | AW | Executor read address (word) |
| buf_rd_data | output | 32 | Buffer word, one cycle after the address |

## Verification
A bypass pulse appears in the cycle after the accepting clock edge. A commit with no padding raises done_valid in the cycle after acceptance. A commit with padding raises it in the cycle after the last zero word is written, which is one cycle per pad word. Buffer contents are final once req_ready is high again. The read port returns a word one cycle after its address. The bench therefore drives every input on the falling edge and waits for req_ready before it reads. It reads each word one full cycle after presenting the address, and it polls for done_valid on falling edges, then confirms that the pulse is gone one cycle later. Expected buffer images, tails and bypass decisions come from a word-level model of the requirements kept inside the bench.

// File: rtl/packer_pkg.sv
package packer_pkg;

  localparam int OFF_W = 20;
  localparam int WORD_W = 32;

  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;
  localparam logic [3:0] BE_ALL     = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DHDR = 3'd1,
    ST_IHDR = 3'd2,
    ST_IVAL = 3'd3,
    ST_CNT  = 3'd4,
    ST_PAD  = 3'd5,
    ST_CPAD = 3'd6
  } pk_state_t;

  function automatic logic [WORD_W-1:0] hdr_direct(input logic [OFF_W-1:0] off);
    return {OP_DIRECT, BE_ALL, off};
  endfunction

  function automatic logic [WORD_W-1:0] hdr_indexed(input logic [OFF_W-1:0] off);
    return {OP_INDEXED, 4'h0, off};
  endfunction

endpackage

// File: rtl/packer_rst_sync.sv
module packer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/packer_ram.sv
module packer_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/packer_fsm.sv
module packer_fsm
  import packer_pkg::*;
#(
  parameter int DEPTH_WORDS = 64,
  parameter int LINE_WORDS  = 16,
  localparam int AW = $clog2(DEPTH_WORDS),
  localparam int PW = $clog2(DEPTH_WORDS + 1),
  localparam int XW = PW + 1,
  localparam int TW = PW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [WORD_W-1:0] req_value,
  input  logic              req_indexed,
  input  logic              commit_valid,
  output logic              ram_we,
  output logic [AW-1:0]     ram_waddr,
  output logic [WORD_W-1:0] ram_wdata,
  output logic              done_valid,
  output logic [TW-1:0]     done_tail_bytes,
  output logic              bypass_valid,
  output logic [OFF_W-1:0]  bypass_offset,
  output logic [WORD_W-1:0] bypass_value
);

  localparam logic [XW-1:0] DEPTH_X = XW'(DEPTH_WORDS);
  localparam logic [XW-1:0] LMASK_X = XW'(LINE_WORDS - 1);

  pk_state_t state_q, state_d;

  logic [PW-1:0]     wp_q, wp_d;
  logic [PW-1:0]     base_q, base_d;
  logic [PW-1:0]     ls_q, ls_d;
  logic [OFF_W-1:0]  loff_q, loff_d;
  logic [PW-1:0]     cnt_q, cnt_d;
  logic              lv_q, lv_d;
  logic [PW-1:0]     tail_q, tail_d;
  logic              done_q, done_d;
  logic [TW-1:0]     dtail_q, dtail_d;
  logic              bpv_q, bpv_d;
  logic [OFF_W-1:0]  off_q, bpo_q;
  logic [WORD_W-1:0] val_q, bpval_q;

  logic [XW-1:0]     wp_x, ev_x, tail_x;
  logic [PW-1:0]     wptr;
  logic              accept, merge_hit, fits;
  logic              fit_merge, fit_new_idx, fit_dir;
  logic              cap_en, bp_en;

  // ---------------- request decode ----------------
  assign req_ready = (state_q == ST_IDLE) && !commit_valid;
  assign accept    = req_valid && req_ready;

  assign wp_x   = {1'b0, wp_q};
  assign ev_x   = wp_x + XW'(wp_q[0]);
  assign tail_x = (wp_x + LMASK_X) & ~LMASK_X;

  assign merge_hit   = req_indexed && lv_q && (req_offset == loff_q);
  assign fit_merge   = wp_x < DEPTH_X;
  assign fit_new_idx = (ev_x + XW'(3)) <= DEPTH_X;
  assign fit_dir     = (ev_x + XW'(2)) <= DEPTH_X;

  always_comb begin
    if (merge_hit)        fits = fit_merge;
    else if (req_indexed) fits = fit_new_idx;
    else                  fits = fit_dir;
  end

  assign cap_en = accept && fits;
  assign bp_en  = accept && !fits;

  // ---------------- next-state logic ----------------
  always_comb begin
    state_d   = state_q;
    wp_d      = wp_q;
    base_d    = base_q;
    ls_d      = ls_q;
    loff_d    = loff_q;
    cnt_d     = cnt_q;
    lv_d      = lv_q;
    tail_d    = tail_q;
    dtail_d   = dtail_q;
    done_d    = 1'b0;
    bpv_d     = 1'b0;
    ram_we    = 1'b0;
    wptr      = '0;
    ram_wdata = '0;

    case (state_q)
      ST_IDLE: begin
        if (commit_valid) begin
          tail_d = tail_x[PW-1:0];
          if (tail_x == wp_x) begin
            done_d  = 1'b1;
            dtail_d = {tail_x[PW-1:0], 2'b00};
            wp_d    = '0;
            lv_d    = 1'b0;
          end else begin
            state_d = ST_CPAD;
          end
        end else if (req_valid) begin
          if (!fits) begin
            bpv_d = 1'b1;
          end else if (merge_hit) begin
            ram_we    = 1'b1;
            wptr      = wp_q;
            ram_wdata = req_value;
            wp_d      = wp_q + 1'b1;
            state_d   = ST_CNT;
          end else if (req_indexed) begin
            ram_we    = 1'b1;
            wptr      = ev_x[PW-1:0];
            ram_wdata = WORD_W'(1);
            base_d    = ev_x[PW-1:0];
            wp_d      = ev_x[PW-1:0] + 1'b1;
            state_d   = ST_IHDR;
          end else begin
            ram_we    = 1'b1;
            wptr      = ev_x[PW-1:0];
            ram_wdata = req_value;
            wp_d      = ev_x[PW-1:0] + 1'b1;
            lv_d      = 1'b0;
            state_d   = ST_DHDR;
          end
        end
      end

      ST_DHDR: begin
        ram_we    = 1'b1;
        wptr      = wp_q;
        ram_wdata = hdr_direct(off_q);
        wp_d      = wp_q + 1'b1;
        state_d   = ST_IDLE;
      end

      ST_IHDR: begin
        ram_we    = 1'b1;
        wptr      = wp_q;
        ram_wdata = hdr_indexed(off_q);
        wp_d      = wp_q + 1'b1;
        state_d   = ST_IVAL;
      end

      ST_IVAL: begin
        ram_we    = 1'b1;
        wptr      = wp_q;
        ram_wdata = val_q;
        wp_d      = wp_q + 1'b1;
        ls_d      = base_q;
        loff_d    = off_q;
        cnt_d     = PW'(1);
        lv_d      = 1'b1;
        state_d   = ST_PAD;
      end

      ST_CNT: begin
        ram_we    = 1'b1;
        wptr      = ls_q;
        ram_wdata = WORD_W'(cnt_q + 1'b1);
        cnt_d     = cnt_q + 1'b1;
        state_d   = wp_q[0] ? ST_PAD : ST_IDLE;
      end

      ST_PAD: begin
        ram_we    = 1'b1;
        wptr      = wp_q;
        ram_wdata = '0;
        state_d   = ST_IDLE;
      end

      ST_CPAD: begin
        ram_we    = 1'b1;
        wptr      = wp_q;
        ram_wdata = '0;
        if ((wp_x + XW'(1)) == {1'b0, tail_q}) begin
          done_d  = 1'b1;
          dtail_d = {tail_q, 2'b00};
          wp_d    = '0;
          lv_d    = 1'b0;
          state_d = ST_IDLE;
        end else begin
          wp_d = wp_q + 1'b1;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  assign ram_waddr = wptr[AW-1:0];

  // ---------------- state registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wp_q    <= '0;
      base_q  <= '0;
      ls_q    <= '0;
      loff_q  <= '0;
      cnt_q   <= '0;
      lv_q    <= 1'b0;
      tail_q  <= '0;
      dtail_q <= '0;
      done_q  <= 1'b0;
      bpv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wp_q    <= wp_d;
      base_q  <= base_d;
      ls_q    <= ls_d;
      loff_q  <= loff_d;
      cnt_q   <= cnt_d;
      lv_q    <= lv_d;
      tail_q  <= tail_d;
      dtail_q <= dtail_d;
      done_q  <= done_d;
      bpv_q   <= bpv_d;
    end
  end

  // request capture, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      val_q <= '0;
    end else if (cap_en) begin
      off_q <= req_offset;
      val_q <= req_value;
    end
  end

  // bypass payload, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpo_q   <= '0;
      bpval_q <= '0;
    end else if (bp_en) begin
      bpo_q   <= req_offset;
      bpval_q <= req_value;
    end
  end

  assign done_valid      = done_q;
  assign done_tail_bytes = dtail_q;
  assign bypass_valid    = bpv_q;
  assign bypass_offset   = bpo_q;
  assign bypass_value    = bpval_q;

  // ---------------- assertions ----------------
  // R8: every buffer write lands below capacity
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ({1'b0, wptr} < DEPTH_X));

  // R8: a bypass pulse always follows an accepted request
  a_r8_bypass_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_valid |-> $past(req_valid && req_ready));

  // R11: a buffered request holds off the next one
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fits) |=> !req_ready);

  // R5: padding only at odd positions
  a_r5_pad_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAD) |-> wp_q[0]);

  // R9: tail lands on a line boundary
  a_r9_tail_line: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_tail_bytes[$clog2(LINE_WORDS)+1:0] == '0));

  // R10: batch state is cleared when the commit finishes
  a_r10_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (wp_q == '0) && !lv_q);

  // R4: a live merge target carries a count between 1 and capacity
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    lv_q |-> (cnt_q != '0) && ({1'b0, cnt_q} <= DEPTH_X));

  // R7: the first word of a new instruction is even
  a_r7_even_start: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fits && !merge_hit) |-> !wptr[0]);

endmodule

// File: rtl/regwr_packer.sv
module regwr_packer
  import packer_pkg::*;
#(
  parameter int DEPTH_WORDS = 64,
  parameter int LINE_BYTES  = 64,
  localparam int LINE_WORDS = LINE_BYTES / 4,
  localparam int AW = $clog2(DEPTH_WORDS),
  localparam int PW = $clog2(DEPTH_WORDS + 1),
  localparam int TW = PW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [19:0]       req_offset,
  input  logic [31:0]       req_value,
  input  logic              req_indexed,
  input  logic              commit_valid,
  output logic              done_valid,
  output logic [TW-1:0]     done_tail_bytes,
  output logic              bypass_valid,
  output logic [19:0]       bypass_offset,
  output logic [31:0]       bypass_value,
  input  logic [AW-1:0]     buf_rd_addr,
  output logic [31:0]       buf_rd_data
);

  logic              rst_n_int;
  logic              ram_we;
  logic [AW-1:0]     ram_waddr;
  logic [WORD_W-1:0] ram_wdata;

  packer_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  packer_fsm #(
    .DEPTH_WORDS (DEPTH_WORDS),
    .LINE_WORDS  (LINE_WORDS)
  ) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n_int),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_offset      (req_offset),
    .req_value       (req_value),
    .req_indexed     (req_indexed),
    .commit_valid    (commit_valid),
    .ram_we          (ram_we),
    .ram_waddr       (ram_waddr),
    .ram_wdata       (ram_wdata),
    .done_valid      (done_valid),
    .done_tail_bytes (done_tail_bytes),
    .bypass_valid    (bypass_valid),
    .bypass_offset   (bypass_offset),
    .bypass_value    (bypass_value)
  );

  packer_ram #(
    .DEPTH (DEPTH_WORDS),
    .DW    (WORD_W)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (buf_rd_addr),
    .rdata (buf_rd_data)
  );

endmodule

// File: tb/sim_regwr_packer.sv
module sim_regwr_packer;

  localparam int D  = 64;
  localparam int AW = 6;
  localparam int TW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_indexed, commit_valid;
  logic [19:0]   req_offset;
  logic [31:0]   req_value;
  logic          done_valid, bypass_valid;
  logic [TW-1:0] done_tail_bytes;
  logic [19:0]   bypass_offset;
  logic [31:0]   bypass_value;
  logic [AW-1:0] buf_rd_addr;
  logic [31:0]   buf_rd_data;

  always #5 clk = ~clk;

  regwr_packer #(.DEPTH_WORDS(D), .LINE_BYTES(64)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_value(req_value), .req_indexed(req_indexed),
    .commit_valid(commit_valid),
    .done_valid(done_valid), .done_tail_bytes(done_tail_bytes),
    .bypass_valid(bypass_valid), .bypass_offset(bypass_offset),
    .bypass_value(bypass_value),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data)
  );

  int n_chk = 0;
  int n_err = 0;

  // word-level model built from the requirements
  logic [31:0] m_mem [D];
  int          m_wp, m_ls, m_cnt;
  logic [19:0] m_loff;
  bit          m_lv;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_req(input logic [19:0] off, input logic [31:0] v,
                       input bit idx, output bit bp);
    int ev;
    ev = m_wp + (m_wp % 2);
    bp = 1'b0;
    if (idx && m_lv && off == m_loff) begin
      if (m_wp >= D) bp = 1'b1;
      else begin
        m_mem[m_wp] = v;
        m_wp++;
        m_cnt++;
        m_mem[m_ls] = 32'(m_cnt);
        if (m_wp % 2 == 1) m_mem[m_wp] = '0;
      end
    end else if (idx) begin
      if (ev + 3 > D) bp = 1'b1;
      else begin
        m_mem[ev]     = 32'd1;
        m_mem[ev + 1] = {8'h09, 4'h0, off};
        m_mem[ev + 2] = v;
        m_ls = ev; m_loff = off; m_cnt = 1; m_lv = 1'b1;
        m_wp = ev + 3;
        m_mem[m_wp] = '0;
      end
    end else begin
      if (ev + 2 > D) bp = 1'b1;
      else begin
        m_mem[ev]     = v;
        m_mem[ev + 1] = {8'h01, 4'hF, off};
        m_wp = ev + 2;
        m_lv = 1'b0;
      end
    end
  endtask

  task automatic wait_idle();
    int k = 0;
    while (!req_ready && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic send(input logic [19:0] off, input logic [31:0] v,
                      input bit idx, input string tag);
    bit bp;
    m_req(off, v, idx, bp);
    wait_idle();
    req_valid = 1'b1; req_offset = off; req_value = v; req_indexed = idx;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R8 bypass flag"}, 64'(bypass_valid), 64'(bp));
    if (bp) begin
      chk({tag, " R8 bypass offset"}, 64'(bypass_offset), 64'(off));
      chk({tag, " R8 bypass value"}, 64'(bypass_value), 64'(v));
    end
  endtask

  task automatic check_buf(input string tag, input int upto);
    wait_idle();
    for (int a = 0; a < upto; a++) begin
      buf_rd_addr = AW'(a);
      @(negedge clk);
      chk($sformatf("%s word %0d", tag, a), 64'(buf_rd_data), 64'(m_mem[a]));
    end
  endtask

  task automatic commit(input string tag);
    int exp_tail, k;
    exp_tail = ((m_wp + 15) / 16) * 16;
    for (int a = m_wp; a < exp_tail; a++) m_mem[a] = '0;
    m_wp = 0; m_lv = 1'b0;
    wait_idle();
    commit_valid = 1'b1;
    #1;
    chk({tag, " R11 ready low under commit"}, 64'(req_ready), 64'd0);
    @(negedge clk);
    commit_valid = 1'b0;
    k = 0;
    while (!done_valid && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk({tag, " R9 done seen"}, 64'(done_valid), 64'd1);
    chk({tag, " R9 tail bytes"}, 64'(done_tail_bytes), 64'(exp_tail * 4));
    @(negedge clk);
    chk({tag, " R9 done single pulse"}, 64'(done_valid), 64'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    chk("R1 bypass idle", 64'(bypass_valid), 64'd0);
    chk("R1 done idle", 64'(done_valid), 64'd0);
    commit("R1 empty commit");
  endtask

  task automatic t_first_zero();
    send(20'h0, 32'h0000_0011, 1'b1, "R6 first indexed offset 0");
    check_buf("R3 R6 new indexed", 4);
    send(20'h0, 32'h0000_0022, 1'b1, "R4 merge");
    check_buf("R4 merged count", 4);
    send(20'h0, 32'h0000_0033, 1'b1, "R5 odd merge");
    check_buf("R5 pad word", 6);
  endtask

  task automatic t_direct_align();
    send(20'h12345, 32'hA5A5_0001, 1'b0, "R7 direct after odd");
    check_buf("R2 R7 direct layout", 8);
  endtask

  task automatic t_break();
    send(20'h0, 32'h0000_0044, 1'b1, "R6 after direct");
    send(20'hABCDE, 32'h0000_0055, 1'b1, "R6 new offset");
    send(20'hABCDE, 32'h0000_0066, 1'b1, "R4 merge even");
    send(20'hABCDE, 32'h0000_0077, 1'b1, "R4 merge odd");
    check_buf("R6 R4 chain", 18);
  endtask

  task automatic t_commit();
    commit("R9 padded commit");
    check_buf("R9 zero fill", 32);
    send(20'hABCDE, 32'h0000_0088, 1'b1, "R10 after commit");
    check_buf("R10 restart at 0", 4);
  endtask

  task automatic t_ready();
    send(20'h00001, 32'h0000_0099, 1'b0, "R11 direct");
    chk("R11 ready low while busy", 64'(req_ready), 64'd0);
    commit("R11 commit");
  endtask

  task automatic t_fill_direct();
    for (int i = 0; i < 31; i++) send(20'(i + 16), 32'(32'hD000_0000 + i), 1'b0, "R8 fill");
    send(20'h00777, 32'hBEEF_0001, 1'b1, "R8 indexed no room");
    send(20'h00778, 32'hBEEF_0002, 1'b0, "R8 last direct fits");
    send(20'h00779, 32'hBEEF_0003, 1'b1, "R8 full indexed");
    send(20'h0077A, 32'hBEEF_0004, 1'b0, "R8 full direct");
    check_buf("R8 buffer untouched", D);
    commit("R9 full commit");
  endtask

  task automatic t_fill_merge();
    send(20'h00100, 32'hC000_0000, 1'b1, "R8 merge base");
    for (int i = 1; i <= 61; i++) send(20'h00100, 32'(32'hC000_0000 + i), 1'b1, "R8 merge fill");
    send(20'h00100, 32'hC0DE_0001, 1'b1, "R8 merge at capacity");
    check_buf("R8 R4 full merge", D);
    commit("R10 commit after full");
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_indexed = 1'b0; commit_valid = 1'b0;
    req_offset = '0; req_value = '0; buf_rd_addr = '0;
    m_wp = 0; m_ls = 0; m_cnt = 0; m_loff = '0; m_lv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first_zero();
    t_direct_align();
    t_break();
    t_commit();
    t_ready();
    t_fill_direct();
    t_fill_merge();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule